// File: doc/BRIEF.md
# Soft Reset Output Sequencer

This block carries out a software-requested restart of a clock generator's output stage. A register write that sets the reset bit sends the block through four steps. It first blanks every output that is not marked always-on. It then runs a calibration and divider-initialization handshake with the analog section, during which synchronous outputs whose divide ratio is one are flagged for phase alignment. Next it waits a fixed lock interval, which is skipped when the calibration override is set. Finally it releases exactly the outputs it blanked.

The reset register is not self-clearing. It keeps whatever value was last written to it, and the block never writes to any configuration register. A busy flag covers the whole run. A reset write that arrives while a run is in progress does not restart it. The lock interval is a cycle count set by a parameter, so a bench can shorten it.

Top module: `srst_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `blank`, `cal_start`, `align_mask` and `rst_reg` are all zero after that edge. This holds even when a sequence was running.
- R2: A write with `wr_en` high, `wr_addr` equal to `RST_ADDR` (default 0xF6) and bit 1 of `wr_data` set makes `busy` go high one cycle later. A write to any other address, or a write with bit 1 clear, starts nothing.
- R3: `rst_reg` takes the full `wr_data` of every write to `RST_ADDR`. It keeps that value afterwards, and bit 1 is never cleared by the block.
- R4: In the cycle the sequence starts, `blank` is loaded with the inverse of `keep_on`, where bit i high means output i is always-on. It holds that value for the whole sequence, even if `keep_on` changes.
- R5: `cal_start` rises one cycle after blanking begins. It stays high until the clock edge at which `cal_done` is sampled high, so it lasts exactly as many cycles as the handshake takes.
- R6: While `cal_start` is high, `align_mask` equals `sync_en & div_one`. At all other times it is zero.
- R7: With `cal_ovrd` low when calibration finishes, the block waits `LOCK_CYC` cycles before release. With `cal_ovrd` high, it waits none. The total length of `busy` is 2 + (calibration cycles) + (`LOCK_CYC` or 0).
- R8: On the edge where `busy` falls, `blank` returns to zero. This re-enables exactly the outputs blanked in step 1.
- R9: A reset write that arrives while `busy` is high neither restarts nor lengthens the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| keep_on | input | N_OUT | Per-output always-on setting |
| sync_en | input | N_OUT | Per-output synchronous-output flag |
| div_one | input | N_OUT | Per-output divide ratio equals one |
| cal_ovrd | input | 1 | Skip the lock interval |
| cal_done | input | 1 | Calibration and divider init complete |
| cal_start | output | 1 | Calibration request, held until done |
| align_mask | output | N_OUT | Outputs to phase-align during calibration |
| blank | output | N_OUT | Per-output forced disable to the enable controller |
| busy | output | 1 | Sequence in progress |
| rst_reg | output | DW | Readback of the reset register |

## Verification
A table of always-on masks, sync and divide-one patterns, override settings and handshake latencies drives complete sequences. Each run's busy length separates the override path from the lock-wait path and exposes any off-by-one in the handshake or timer. Masks that are all-set, all-clear and mixed check that blanking and alignment follow the proper per-output bits. Directed runs change `keep_on` and repeat the reset write in the middle of a sequence, which tells a latched mask from a live one and a run that ignores the repeat from one that restarts. A wrong address, a clear bit 1 and a reset in mid-sequence cover the cases where nothing should start.

// File: rtl/srst_pkg.sv
// Shared types for the soft reset sequencer.
// Assumes: one clock domain, synchronous active-low reset.
package srst_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_BLANK   = 3'd1,
        SQ_CAL     = 3'd2,
        SQ_LOCK    = 3'd3,
        SQ_RELEASE = 3'd4
    } sq_state_t;
endpackage

// File: rtl/srst_regif.sv
// Reset register capture and start-request decode.
// Holds the last value written to RST_ADDR; never clears itself.
// Assumes: writes are single-cycle strobes.
module srst_regif #(
    parameter int              AW       = 8,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   RST_ADDR = 8'hF6,
    parameter int              RST_BIT  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rst_reg,
    output logic          start_req
);
    logic hit;

    // Address decode for the reset register.
    assign hit       = wr_en && (wr_addr == RST_ADDR);
    // A start is requested whenever the written value sets the reset bit.
    assign start_req = hit && wr_data[RST_BIT];

    // Register storage: takes the written value, keeps it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_reg <= '0;
        else if (hit)
            rst_reg <= wr_data;
    end

    assert_reg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == RST_ADDR) |=> $stable(rst_reg));
endmodule

// File: rtl/srst_lock_timer.sv
// Counts the lock interval in reference-clock cycles while enabled.
// Assumes: run stays high until done is seen; LOCK_CYC >= 1.
module srst_lock_timer #(
    parameter int LOCK_CYC = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

    logic [CW-1:0] cnt;

    // Terminal count reached in the current cycle.
    assign done = run && (cnt == LAST);

    // Cycle counter, cleared whenever the wait is not active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_cnt_only_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $past(run));
endmodule

// File: rtl/srst_blank_ctrl.sv
// Per-output blanking latch and phase-alignment mask.
// Captures the not-always-on set at start and clears it at release.
// Assumes: capture and release_i are never high together.
module srst_blank_ctrl #(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             release_i,
    input  logic             align_en,
    input  logic [N_OUT-1:0] keep_on,
    input  logic [N_OUT-1:0] sync_en,
    input  logic [N_OUT-1:0] div_one,
    output logic [N_OUT-1:0] blank,
    output logic [N_OUT-1:0] align_mask
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // Blank latch for output i: set unless always-on, cleared on release.
        always_ff @(posedge clk) begin
            if (!rst_n)
                blank[i] <= 1'b0;
            else if (capture)
                blank[i] <= ~keep_on[i];
            else if (release_i)
                blank[i] <= 1'b0;
        end
        // Alignment flag for output i during calibration.
        assign align_mask[i] = align_en & sync_en[i] & div_one[i];
    end

    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> (blank == '0));
endmodule

// File: rtl/srst_seq.sv
// Soft reset output sequencer: blank, calibrate, lock-wait, release.
// Assumes: cal_done is answered only while cal_start is high; all inputs
// are synchronous to clk; configuration inputs are static registers.
module srst_seq
    import srst_pkg::*;
#(
    parameter int            N_OUT    = 4,
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] RST_ADDR = 8'hF6,
    parameter int            RST_BIT  = 1,
    parameter int            LOCK_CYC = 625000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [N_OUT-1:0] keep_on,
    input  logic [N_OUT-1:0] sync_en,
    input  logic [N_OUT-1:0] div_one,
    input  logic             cal_ovrd,
    input  logic             cal_done,
    output logic             cal_start,
    output logic [N_OUT-1:0] align_mask,
    output logic [N_OUT-1:0] blank,
    output logic             busy,
    output logic [DW-1:0]    rst_reg
);
    sq_state_t state, state_nx;
    logic      start_req;
    logic      lock_done;

    srst_regif #(
        .AW(AW), .DW(DW), .RST_ADDR(RST_ADDR), .RST_BIT(RST_BIT)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rst_reg(rst_reg), .start_req(start_req)
    );

    srst_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == SQ_LOCK), .done(lock_done)
    );

    srst_blank_ctrl #(.N_OUT(N_OUT)) u_blank (
        .clk(clk), .rst_n(rst_n),
        .capture(state == SQ_IDLE && start_req),
        .release_i(state == SQ_RELEASE),
        .align_en(state == SQ_CAL),
        .keep_on(keep_on), .sync_en(sync_en), .div_one(div_one),
        .blank(blank), .align_mask(align_mask)
    );

    // Next-state selection; starts are only accepted from idle.
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:    if (start_req) state_nx = SQ_BLANK;
            SQ_BLANK:   state_nx = SQ_CAL;
            SQ_CAL:     if (cal_done) state_nx = cal_ovrd ? SQ_RELEASE : SQ_LOCK;
            SQ_LOCK:    if (lock_done) state_nx = SQ_RELEASE;
            SQ_RELEASE: state_nx = SQ_IDLE;
            default:    state_nx = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SQ_IDLE;
        else
            state <= state_nx;
    end

    // Status and handshake outputs decoded from the state.
    assign busy      = (state != SQ_IDLE);
    assign cal_start = (state == SQ_CAL);

    assert_start_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_addr == RST_ADDR && wr_data[RST_BIT]));
    assert_blank_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(blank));
    assert_cal_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> busy);
    assert_align_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_start |-> (align_mask == '0));
    assert_idle_unblanked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (blank == '0));
endmodule

// File: tb/srst_seq_bench.sv
module srst_seq_bench;
    localparam int            N        = 4;
    localparam int            L        = 20;
    localparam logic [7:0]    RA       = 8'hF6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic [N-1:0] keep_on = '0, sync_en = '0, div_one = '0;
    logic cal_ovrd = 1'b0, cal_done = 1'b0;
    logic cal_start, busy;
    logic [N-1:0] align_mask, blank;
    logic [7:0] rst_reg;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    srst_seq #(.N_OUT(N), .AW(8), .DW(8), .RST_ADDR(RA), .RST_BIT(1), .LOCK_CYC(L)) u_srst_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .keep_on(keep_on), .sync_en(sync_en), .div_one(div_one), .cal_ovrd(cal_ovrd),
        .cal_done(cal_done), .cal_start(cal_start), .align_mask(align_mask),
        .blank(blank), .busy(busy), .rst_reg(rst_reg)
    );

    // {keep_on, sync_en, div_one, cal_ovrd, handshake cycles}
    localparam logic [16:0] VEC [0:7] = '{
        {4'b0000, 4'b1111, 4'b1111, 1'b0, 4'd1},
        {4'b1111, 4'b0000, 4'b0000, 1'b0, 4'd3},
        {4'b0101, 4'b1100, 4'b1010, 1'b1, 4'd2},
        {4'b1010, 4'b0011, 4'b0111, 1'b0, 4'd5},
        {4'b0000, 4'b1111, 4'b0000, 1'b1, 4'd1},
        {4'b1001, 4'b0110, 4'b0110, 1'b1, 4'd4},
        {4'b0110, 4'b1001, 4'b1111, 1'b0, 4'd2},
        {4'b0001, 4'b1110, 4'b1101, 1'b0, 4'd7}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_seq(input logic [N-1:0] k, input logic [N-1:0] s, input logic [N-1:0] d,
                           input logic ov, input int dly, input bit poke);
        int busy_n = 0;
        int cal_n = 0;
        int blank_bad = 0;
        int align_bad = 0;
        keep_on = k; sync_en = s; div_one = d; cal_ovrd = ov; cal_done = 1'b0;
        wr(RA, 8'h02);
        chk(busy == 1'b1, "R2 busy after write", int'(busy), 1);
        while (busy && busy_n < 2000) begin
            busy_n++;
            if (blank !== ~k) blank_bad++;
            if (cal_start) begin
                cal_n++;
                if (align_mask !== (s & d)) align_bad++;
                cal_done = (cal_n == dly);
            end else begin
                if (align_mask != '0) align_bad++;
                cal_done = 1'b0;
            end
            if (poke && busy_n == 1) begin
                keep_on = ~k; wr_en = 1'b1; wr_addr = RA; wr_data = 8'h02;
            end
            if (poke && busy_n == 2) wr_en = 1'b0;
            @(negedge clk);
        end
        cal_done = 1'b0; wr_en = 1'b0;
        chk(blank_bad == 0, "R4 blank held at ~keep_on", blank_bad, 0);
        chk(cal_n == dly, "R5 cal_start cycles", cal_n, dly);
        chk(align_bad == 0, "R6 align mask", align_bad, 0);
        chk(busy_n == 2 + dly + (ov ? 0 : L), poke ? "R9 busy length with repeat write" : "R7 busy length",
            busy_n, 2 + dly + (ov ? 0 : L));
        chk(blank == '0, "R8 blank released", int'(blank), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(blank == '0, "R1 blank", int'(blank), 0);
        chk(cal_start == 1'b0, "R1 cal_start", int'(cal_start), 0);
        chk(rst_reg == 8'h00, "R1 rst_reg", int'(rst_reg), 0);

        // R2: wrong address starts nothing
        wr(8'h10, 8'h02);
        chk(busy == 1'b0, "R2 wrong address", int'(busy), 0);
        chk(rst_reg == 8'h00, "R3 other address leaves reg", int'(rst_reg), 0);
        // R2/R3: bit 1 clear starts nothing but is stored
        wr(RA, 8'hFD);
        chk(busy == 1'b0, "R2 bit clear", int'(busy), 0);
        chk(rst_reg == 8'hFD, "R3 reg value", int'(rst_reg), 'hFD);

        for (int v = 0; v < 8; v++) begin
            run_seq(VEC[v][16:13], VEC[v][12:9], VEC[v][8:5], VEC[v][4], int'(VEC[v][3:0]), 1'b0);
        end

        // R3: reset bit not self-clearing
        repeat (3) @(negedge clk);
        chk(rst_reg == 8'h02, "R3 bit stays set", int'(rst_reg), 2);
        wr(RA, 8'h00);
        chk(rst_reg == 8'h00, "R3 cleared by write", int'(rst_reg), 0);
        chk(busy == 1'b0, "R2 zero write no start", int'(busy), 0);

        // R8/R9: keep_on changes and a repeat write mid-sequence
        run_seq(4'b0011, 4'b1111, 4'b0101, 1'b0, 3, 1'b1);
        run_seq(4'b1100, 4'b0101, 4'b1111, 1'b1, 2, 1'b1);

        // R1: reset in the middle of a sequence
        keep_on = 4'b0000; cal_ovrd = 1'b0;
        wr(RA, 8'h02);
        repeat (2) @(negedge clk);
        chk(cal_start == 1'b1, "R5 cal_start before reset", int'(cal_start), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 mid-run busy", int'(busy), 0);
        chk(blank == '0, "R1 mid-run blank", int'(blank), 0);
        chk(cal_start == 1'b0 && align_mask == '0, "R1 mid-run cal", int'(cal_start), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R1 stays idle", int'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule